// File: doc/BRIEF.md
# Toggle-Handshake Single-Word Clock Crossing

This block carries one data word at a time from a source clock domain into an unrelated destination clock domain. The source side offers the word with a valid/ready pair. When a word is accepted, the source side latches it into a hold register and inverts a single request level. The destination side compares the synchronized request with its own remembered level. When the two differ, it inverts the remembered level, captures the held word and raises a one-cycle valid pulse. The remembered level goes back to the source as the acknowledge.

The source stays blocked, with ready low, until the returned acknowledge matches the request again. So at most one toggle is ever in flight, and a word can be neither lost nor duplicated. The hold register does not change while a word is in flight, so the data bus crosses without synchronizers. Only the two single-bit levels pass through flop chains. Both levels reset to zero, so no transfer appears after reset.

Top module: `tgl_xfer`

## Requirements
- R1: After reset, src_ready is 1 and dst_valid is 0, and with no send no dst_valid pulse ever appears.
- R2: A word is accepted only on a src_clk edge where src_valid and src_ready are both 1, and each accepted word produces exactly one dst_valid pulse.
- R3: In the src_clk cycle after an accept, src_ready is 0, and the held word and request level stay unchanged until src_ready returns to 1.
- R4: dst_valid is high for exactly one dst_clk cycle per word, and is never high in two consecutive cycles.
- R5: Words appear on dst_data, sampled while dst_valid is 1, in the order they were accepted and with their exact values.
- R6: While src_ready is 0, holding src_valid high or changing src_data causes no extra transfer and does not alter the word in flight.
- R7: R2, R4 and R5 hold when dst_clk is slower than src_clk and also when it is faster.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain reset, active low, asynchronous assert |
| src_valid | input | 1 | Source offers a word |
| src_ready | output | 1 | Source side can take a word |
| src_data | input | DATA_W | Word offered by the source |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination domain reset, active low, asynchronous assert |
| dst_valid | output | 1 | One-cycle pulse marking a delivered word |
| dst_data | output | DATA_W | Delivered word, meaningful while dst_valid is 1 |

## Verification
The main function is tried with back-to-back offers, which show whether the blocking on the acknowledge loses or repeats words, and with random stall gaps, which show whether idle periods create false requests. Both patterns are run with the destination clock slower than the source and then faster, since only the slow-destination case would expose a double toggle cancelling out. A directed pattern holds valid high with new data while ready is low, to tell a correct block from one that accepts while busy. A quiet period after reset checks that matched reset levels give no phantom word.

// File: rtl/tgl_xfer_pkg.sv
package tgl_xfer_pkg;
  typedef enum logic {
    RX_IDLE = 1'b0,
    RX_READ = 1'b1
  } rx_state_e;
endpackage

// File: rtl/tgl_sync_bit.sv
module tgl_sync_bit #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = d_async;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], d_async};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/tgl_src.sv
module tgl_src #(
  parameter int DATA_W = 16,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              ack_tgl,
  output logic              req_tgl,
  output logic [DATA_W-1:0] hold_data
);
  logic              ack_s;
  logic              req_q, req_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              take;

  tgl_sync_bit #(.STAGES(SYNC_N)) u_ack_sync (
    .clk(clk), .rst_n(rst_n), .d_async(ack_tgl), .q_sync(ack_s)
  );

  always_comb begin
    in_ready = (ack_s == req_q);
    take     = in_valid && in_ready;
    req_d    = req_q;
    data_d   = data_q;
    if (take) begin
      req_d  = ~req_q;
      data_d = in_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      data_q <= '0;
    end else begin
      req_q  <= req_d;
      data_q <= data_d;
    end
  end

  assign req_tgl   = req_q;
  assign hold_data = data_q;

  // R3: an accept closes the door for at least the next cycle
  p_ready_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R3, R6: word and request frozen while a transfer is in flight
  p_hold_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> ($stable(hold_data) && $stable(req_tgl)));
endmodule

// File: rtl/tgl_dst.sv
module tgl_dst #(
  parameter int DATA_W = 16,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_tgl,
  input  logic [DATA_W-1:0] hold_data,
  output logic              seen_tgl,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  import tgl_xfer_pkg::*;

  logic              req_s;
  rx_state_e         st_q, st_d;
  logic              seen_q, seen_d;
  logic [DATA_W-1:0] cap_q, cap_d;

  tgl_sync_bit #(.STAGES(SYNC_N)) u_req_sync (
    .clk(clk), .rst_n(rst_n), .d_async(req_tgl), .q_sync(req_s)
  );

  always_comb begin
    st_d   = st_q;
    seen_d = seen_q;
    cap_d  = cap_q;
    unique case (st_q)
      RX_IDLE: begin
        if (req_s != seen_q) begin
          seen_d = ~seen_q;
          cap_d  = hold_data;
          st_d   = RX_READ;
        end
      end
      RX_READ: st_d = RX_IDLE;
      default: st_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      seen_q <= 1'b0;
      cap_q  <= '0;
    end else begin
      st_q   <= st_d;
      seen_q <= seen_d;
      cap_q  <= cap_d;
    end
  end

  assign seen_tgl  = seen_q;
  assign out_valid = (st_q == RX_READ);
  assign out_data  = cap_q;

  // R4: delivery is a single-cycle pulse
  p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R2: a detected request difference is delivered next cycle
  p_detect_deliver_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && (req_s != seen_tgl)) |=> out_valid);

  // R2: the returned level only moves when a word is delivered
  p_seen_moves_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(seen_tgl) |-> out_valid);
endmodule

// File: rtl/tgl_xfer.sv
module tgl_xfer #(
  parameter int DATA_W = 16,
  parameter int SYNC_N = 2
) (
  input  logic              src_clk,
  input  logic              src_rst_n,
  input  logic              src_valid,
  output logic              src_ready,
  input  logic [DATA_W-1:0] src_data,
  input  logic              dst_clk,
  input  logic              dst_rst_n,
  output logic              dst_valid,
  output logic [DATA_W-1:0] dst_data
);
  logic              req_tgl;
  logic              seen_tgl;
  logic [DATA_W-1:0] hold_data;

  tgl_src #(.DATA_W(DATA_W), .SYNC_N(SYNC_N)) u_src (
    .clk(src_clk), .rst_n(src_rst_n),
    .in_valid(src_valid), .in_ready(src_ready), .in_data(src_data),
    .ack_tgl(seen_tgl), .req_tgl(req_tgl), .hold_data(hold_data)
  );

  tgl_dst #(.DATA_W(DATA_W), .SYNC_N(SYNC_N)) u_dst (
    .clk(dst_clk), .rst_n(dst_rst_n),
    .req_tgl(req_tgl), .hold_data(hold_data), .seen_tgl(seen_tgl),
    .out_valid(dst_valid), .out_data(dst_data)
  );
endmodule

// File: tb/tgl_xfer_bench.sv
module tgl_xfer_bench;
  localparam int W = 16;
  localparam int N = 12;
  localparam logic [W-1:0] WORDS [N] = '{
    16'h0001, 16'hFFFF, 16'hA5A5, 16'h5A5A, 16'h0000, 16'h8000,
    16'h1234, 16'h1234, 16'hBEEF, 16'h00FF, 16'hFF00, 16'h7FFE};
  localparam int GAPS [N] = '{0, 0, 3, 0, 7, 1, 0, 0, 12, 2, 0, 5};

  logic src_clk = 1'b0, dst_clk = 1'b0;
  logic src_rst_n, dst_rst_n;
  logic src_valid, src_ready, dst_valid;
  logic [W-1:0] src_data, dst_data;
  int dst_half = 13;

  int total = 0, bad = 0;
  int sent = 0, rcvd = 0;
  logic [W-1:0] log_q [64];
  bit finished = 1'b0;

  always #4 src_clk = ~src_clk;           // 125 MHz
  always #(dst_half) dst_clk = ~dst_clk;

  tgl_xfer #(.DATA_W(W), .SYNC_N(2)) u_tgl_xfer (
    .src_clk(src_clk), .src_rst_n(src_rst_n), .src_valid(src_valid),
    .src_ready(src_ready), .src_data(src_data),
    .dst_clk(dst_clk), .dst_rst_n(dst_rst_n),
    .dst_valid(dst_valid), .dst_data(dst_data));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R2, R4, R5: every pulse must match the next logged word
  always @(negedge dst_clk) begin
    if (dst_rst_n && dst_valid) begin
      if (rcvd >= sent) chk(1'b0, "R2 spurious word", rcvd + 1, sent);
      else begin
        chk(dst_data == log_q[rcvd], "R5 word order/value", dst_data, log_q[rcvd]);
        rcvd++;
      end
    end
  end

  logic last_v = 1'b0;
  always @(negedge dst_clk) begin
    if (dst_rst_n && dst_valid && last_v) chk(1'b0, "R4 pulse width", 2, 1);
    last_v = dst_valid;
  end

  task automatic send(input logic [W-1:0] w);
    src_valid = 1'b1;
    src_data  = w;
    while (!src_ready) @(negedge src_clk);
    @(posedge src_clk);
    log_q[sent] = w;
    sent++;
    @(negedge src_clk);
    chk(src_ready == 1'b0, "R3 ready after accept", src_ready, 0);
    src_valid = 1'b0;
  endtask

  task automatic drain();
    for (int k = 0; k < 200 && rcvd != sent; k++) @(negedge src_clk);
    repeat (20) @(negedge src_clk);
    chk(rcvd == sent, "R2 R7 exactly once", rcvd, sent);
  endtask

  task automatic run_table(input string tag);
    for (int i = 0; i < N; i++) begin
      send(WORDS[i]);
      repeat (GAPS[i]) @(negedge src_clk);
    end
    drain();
    $display("table pass done: %s", tag);
  endtask

  initial begin
    src_rst_n = 1'b0; dst_rst_n = 1'b0;
    src_valid = 1'b0; src_data = '0;
    repeat (3) @(negedge src_clk);
    src_rst_n = 1'b1;
    @(negedge dst_clk);
    dst_rst_n = 1'b1;
    @(negedge src_clk);
    // R1: reset state and no phantom word
    chk(src_ready == 1'b1, "R1 ready after reset", src_ready, 1);
    chk(dst_valid == 1'b0, "R1 valid after reset", dst_valid, 0);
    repeat (30) @(negedge src_clk);
    chk(rcvd == 0, "R1 no start-up transfer", rcvd, 0);

    // R7: destination slower than source
    run_table("slow destination");

    // R6: keep offering new data while blocked
    send(16'hC0DE);
    src_valid = 1'b1;
    src_data  = 16'hDEAD;
    @(negedge src_clk);
    chk(src_ready == 1'b0, "R6 still blocked", src_ready, 0);
    @(negedge src_clk);
    src_valid = 1'b0;
    drain();
    chk(log_q[sent-1] == 16'hC0DE, "R6 word in flight", log_q[sent-1], 16'hC0DE);

    // R7: destination faster than source
    dst_half = 3;
    repeat (10) @(negedge src_clk);
    run_table("fast destination");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge src_clk);
      if (finished) break;
    end
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", rcvd, sent);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule